// File: doc/BRIEF.md
# AHB master transfer sequencer

This block turns processor-side transfer requests into AHB address and data phases. Two kinds of request reach it. A block request carries a start address, a word count and a direction: a block load reads words from the bus and a block store writes them. A single instruction fetch request carries one address. The block drives HTRANS, HADDR, HWRITE and HWDATA, samples HRDATA and follows HREADY. It chooses NONSEQ, SEQ and IDLE so that every transfer appears on the bus in a fixed pattern. The rule for the cycle after a burst depends on the direction of the burst. After a store, a waiting fetch takes the slot of the trailing IDLE. After a load, the IDLE is always issued.

A requester raises `blk_req` or `fch_req` with its operands and holds them stable until it sees completion. A block request completes on `blk_ack`. A fetch completes when `rd_valid` is high with `rd_fetch` set. Store data is supplied combinationally on `wr_data` for the beat index shown on `wr_beat`. Each loaded or fetched word is returned on `rd_data` together with `rd_valid`.

The control FSM has five states:
- `ST_REST`: the bus rests with IDLE on HTRANS.
- `ST_BURST`: the block beats are issued.
- `ST_TAIL`: the IDLE after a burst.
- `ST_FETCH`: the NONSEQ of a fetch.
- `ST_FWAIT`: the IDLE after a fetch.

The transitions are:
- REST→BURST when a block request is pending. A block request wins over a fetch request.
- REST→FETCH when only a fetch request is pending.
- BURST→BURST while beats remain.
- BURST→FETCH on the last beat of a store while a fetch is pending. This is the merge.
- BURST→TAIL on any other last beat.
- TAIL→FETCH when a fetch is pending.
- TAIL→REST otherwise.
- FETCH→FWAIT, always.
- FWAIT→REST, always.

The state moves only in cycles where HREADY is high.

Top module: `ahbseq_top`

## Requirements
- R1: After reset, and with no request pending, HTRANS is IDLE (2'b00), HWRITE is low, and `rd_valid` and `blk_ack` are low.
- R2: A block of N words puts NONSEQ (2'b10) on HTRANS for its first address phase and SEQ (2'b11) for each of the N-1 later ones. HADDR starts at the request address and rises by 4 on each beat.
- R3: A block store with no fetch pending at its last beat is followed by exactly one IDLE address phase.
- R4: A block store whose last beat is accepted while a fetch is pending is followed directly by the fetch's NONSEQ, with no IDLE between them.
- R5: A block load is always followed by exactly one IDLE address phase, even when a fetch is pending. A pending fetch then starts on the next accepted cycle.
- R6: A fetch appears as one NONSEQ at the fetch address followed by one IDLE. Its word is returned with `rd_valid` and `rd_fetch` high.
- R7: HWRITE is high in every address phase of a block store and low in the address phases of loads, fetches and IDLE cycles.
- R8: In the data phase of store beat k, HWDATA equals `wr_data` while `wr_beat` reads k. The words of a block load are returned on `rd_data` in address order with `rd_fetch` low.
- R9: While HREADY is low, HTRANS, HADDR, HWRITE and HWDATA keep their values and the sequence does not advance.
- R10: A one-word block load or store issues a single NONSEQ with no SEQ. The end-of-transfer rules R3, R4 and R5 still apply.
- R11: `blk_ack` is high for exactly one accepted cycle per block request: the cycle in which the last data phase completes.
- R12: When a block request and a fetch request are both pending with the bus at rest, the block goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_req | input | 1 | Block request pending; held until `blk_ack` |
| blk_write | input | 1 | 1 = block store, 0 = block load |
| blk_addr | input | AW | Start byte address of the block |
| blk_words | input | CW | Number of words in the block, at least 1 |
| blk_ack | output | 1 | Last data phase of the block completes this cycle |
| wr_beat | output | CW | Index of the store beat in its data phase |
| wr_data | input | DW | Store word for beat `wr_beat` |
| fch_req | input | 1 | Fetch request pending; held until the fetch word returns |
| fch_addr | input | AW | Fetch byte address |
| rd_valid | output | 1 | A load or fetch word is on `rd_data` this cycle |
| rd_fetch | output | 1 | The returned word belongs to a fetch |
| rd_data | output | DW | Returned word |
| htrans | output | 2 | Bus transfer type |
| haddr | output | AW | Bus address |
| hwrite | output | 1 | Bus write indicator |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Bus ready; low extends the current phases |

## Verification
The assertions rely on these input conditions:
- Every accepted block request carries a word count of at least 1.
- A requester keeps its request and operands steady until completion.
- A requester drops its request before the bus returns to rest.
- `wr_data` depends only on `wr_beat`, so HWDATA can be held stable during stalls.

The stimulus meets these conditions by construction:
- It raises a request only while the block is at rest.
- It holds each request until the completion signal has been observed.
- It withdraws the request in the following cycle.
- It derives its store data from `wr_beat` alone.

Some runs hold HREADY low in every third cycle, including cycles inside bursts and fetches.

// File: rtl/ahbseq_pkg.sv
`timescale 1ns/1ps
package ahbseq_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    typedef enum logic [2:0] {
        ST_REST  = 3'd0,
        ST_BURST = 3'd1,
        ST_TAIL  = 3'd2,
        ST_FETCH = 3'd3,
        ST_FWAIT = 3'd4
    } seq_state_e;

    // Attributes of the address phase that becomes a data phase next
    typedef struct packed {
        logic active;
        logic write;
        logic fetch;
        logic last;
    } dphase_t;

endpackage

// File: rtl/ahbseq_ctrl.sv
`timescale 1ns/1ps
module ahbseq_ctrl
    import ahbseq_pkg::*;
#(
    parameter int CW = 8
)
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic          blk_req,
    input  logic          blk_write,
    input  logic [CW-1:0] blk_words,
    input  logic          fch_req,
    output htrans_e       trans,
    output logic          wr_en,
    output logic          load_blk,
    output logic          load_fch,
    output logic          step,
    output logic          ap_active,
    output logic          ap_fetch,
    output logic          ap_last,
    output logic [CW-1:0] ap_beat
);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] remain_q;
    logic [CW-1:0] beat_q;
    logic          write_q;
    logic          is_last;
    logic          take_blk;

    assign is_last  = (remain_q == CW'(1));
    assign take_blk = (state_q == ST_REST) && blk_req;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REST: begin
                if (blk_req)
                    state_d = ST_BURST;
                else if (fch_req)
                    state_d = ST_FETCH;
            end
            ST_BURST: begin
                if (is_last)
                    state_d = (write_q && fch_req) ? ST_FETCH : ST_TAIL;
            end
            ST_TAIL:  state_d = fch_req ? ST_FETCH : ST_REST;
            ST_FETCH: state_d = ST_FWAIT;
            ST_FWAIT: state_d = ST_REST;
            default:  state_d = ST_REST;
        endcase
    end

    // State register: advances only with an accepted cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_REST;
        else if (hready)
            state_q <= state_d;
    end

    // Beat bookkeeping for the running block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            beat_q   <= '0;
            write_q  <= 1'b0;
        end else if (hready) begin
            if (take_blk) begin
                remain_q <= blk_words;
                beat_q   <= '0;
                write_q  <= blk_write;
            end else if (state_q == ST_BURST) begin
                remain_q <= remain_q - CW'(1);
                beat_q   <= beat_q + CW'(1);
            end
        end
    end

    // Address-phase outputs
    always_comb begin
        trans     = TR_IDLE;
        wr_en     = 1'b0;
        ap_active = 1'b0;
        ap_fetch  = 1'b0;
        ap_last   = 1'b0;
        unique case (state_q)
            ST_BURST: begin
                trans     = (beat_q == '0) ? TR_NONSEQ : TR_SEQ;
                wr_en     = write_q;
                ap_active = 1'b1;
                ap_last   = is_last;
            end
            ST_FETCH: begin
                trans     = TR_NONSEQ;
                ap_active = 1'b1;
                ap_fetch  = 1'b1;
            end
            default: ;
        endcase
    end

    assign ap_beat  = beat_q;
    assign load_blk = hready && take_blk;
    assign load_fch = hready && (state_d == ST_FETCH) && (state_q != ST_FETCH);
    assign step     = hready && (state_q == ST_BURST) && !is_last;

    // Input assumption: an accepted block carries at least one word
    words_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REST && blk_req) |-> (blk_words != '0));

    // R3 R5
    tail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && state_q == ST_BURST && is_last && !(write_q && fch_req))
        |=> (trans == TR_IDLE));

    // R4
    store_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && state_q == ST_BURST && is_last && write_q && fch_req)
        |=> (trans == TR_NONSEQ && !wr_en));

    // R6
    fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && state_q == ST_FETCH) |=> (trans == TR_IDLE));

endmodule

// File: rtl/ahbseq_addr.sv
`timescale 1ns/1ps
module ahbseq_addr
#(
    parameter int AW = 32,
    parameter int DW = 32
)
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_blk,
    input  logic          load_fch,
    input  logic          step,
    input  logic [AW-1:0] blk_addr,
    input  logic [AW-1:0] fch_addr,
    output logic [AW-1:0] haddr
);

    localparam int WB  = DW / 8;
    localparam int LSB = $clog2(WB);

    logic [AW-1:0] addr_q;

    function automatic logic [AW-1:0] word_align(input logic [AW-1:0] a);
        return {a[AW-1:LSB], {LSB{1'b0}}};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load_blk)
            addr_q <= word_align(blk_addr);
        else if (load_fch)
            addr_q <= word_align(fch_addr);
        else if (step)
            addr_q <= addr_q + AW'(WB);
    end

    assign haddr = addr_q;

endmodule

// File: rtl/ahbseq_dphase.sv
`timescale 1ns/1ps
module ahbseq_dphase
    import ahbseq_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 8
)
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic          ap_active,
    input  logic          ap_write,
    input  logic          ap_fetch,
    input  logic          ap_last,
    input  logic [CW-1:0] ap_beat,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] hrdata,
    output logic [DW-1:0] hwdata,
    output logic [CW-1:0] wr_beat,
    output logic          rd_valid,
    output logic          rd_fetch,
    output logic [DW-1:0] rd_data,
    output logic          blk_ack
);

    dphase_t       dp_q;
    logic [CW-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q   <= '0;
            beat_q <= '0;
        end else if (hready) begin
            dp_q   <= '{active: ap_active, write: ap_write,
                        fetch: ap_fetch, last: ap_last};
            beat_q <= ap_beat;
        end
    end

    assign wr_beat  = beat_q;
    assign hwdata   = (dp_q.active && dp_q.write) ? wr_data : '0;
    assign rd_valid = dp_q.active && !dp_q.write && hready;
    assign rd_fetch = dp_q.fetch;
    assign rd_data  = hrdata;
    assign blk_ack  = dp_q.active && dp_q.last && hready;

    // R11
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ack |=> !blk_ack);

endmodule

// File: rtl/ahbseq_top.sv
`timescale 1ns/1ps
module ahbseq_top
    import ahbseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 8
)
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_req,
    input  logic          blk_write,
    input  logic [AW-1:0] blk_addr,
    input  logic [CW-1:0] blk_words,
    output logic          blk_ack,
    output logic [CW-1:0] wr_beat,
    input  logic [DW-1:0] wr_data,
    input  logic          fch_req,
    input  logic [AW-1:0] fch_addr,
    output logic          rd_valid,
    output logic          rd_fetch,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    htrans,
    output logic [AW-1:0] haddr,
    output logic          hwrite,
    output logic [DW-1:0] hwdata,
    input  logic [DW-1:0] hrdata,
    input  logic          hready
);

    localparam int WB = DW / 8;

    htrans_e       trans_w;
    logic          wr_en_w;
    logic          load_blk_w, load_fch_w, step_w;
    logic          ap_active_w, ap_fetch_w, ap_last_w;
    logic [CW-1:0] ap_beat_w;

    ahbseq_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hready    (hready),
        .blk_req   (blk_req),
        .blk_write (blk_write),
        .blk_words (blk_words),
        .fch_req   (fch_req),
        .trans     (trans_w),
        .wr_en     (wr_en_w),
        .load_blk  (load_blk_w),
        .load_fch  (load_fch_w),
        .step      (step_w),
        .ap_active (ap_active_w),
        .ap_fetch  (ap_fetch_w),
        .ap_last   (ap_last_w),
        .ap_beat   (ap_beat_w)
    );

    ahbseq_addr #(.AW(AW), .DW(DW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_blk (load_blk_w),
        .load_fch (load_fch_w),
        .step     (step_w),
        .blk_addr (blk_addr),
        .fch_addr (fch_addr),
        .haddr    (haddr)
    );

    ahbseq_dphase #(.DW(DW), .CW(CW)) u_dphase (
        .clk       (clk),
        .rst_n     (rst_n),
        .hready    (hready),
        .ap_active (ap_active_w),
        .ap_write  (wr_en_w),
        .ap_fetch  (ap_fetch_w),
        .ap_last   (ap_last_w),
        .ap_beat   (ap_beat_w),
        .wr_data   (wr_data),
        .hrdata    (hrdata),
        .hwdata    (hwdata),
        .wr_beat   (wr_beat),
        .rd_valid  (rd_valid),
        .rd_fetch  (rd_fetch),
        .rd_data   (rd_data),
        .blk_ack   (blk_ack)
    );

    assign htrans = trans_w;
    assign hwrite = wr_en_w;

    // R2
    seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && htrans != 2'b00)
        |=> (htrans != 2'b11 || haddr == $past(haddr) + AW'(WB)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> ($stable(htrans) && $stable(haddr) && $stable(hwrite)));

    // R7
    hwrite_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hwrite |-> (htrans != 2'b00));

endmodule

// File: tb/ahbseq_top_bench.sv
`timescale 1ns/1ps
module ahbseq_top_bench;

    localparam logic [31:0] RD_MASK = 32'h3C3C_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_req = 1'b0, blk_write = 1'b0;
    logic [31:0] blk_addr = '0;
    logic [7:0]  blk_words = '0;
    logic        fch_req = 1'b0;
    logic [31:0] fch_addr = '0;
    logic        hready = 1'b1;
    logic        blk_ack, rd_valid, rd_fetch, hwrite;
    logic [7:0]  wr_beat;
    logic [31:0] wr_data, rd_data, haddr, hwdata, hrdata;
    logic [1:0]  htrans;
    logic [31:0] dph_addr = '0;

    always #4 clk = ~clk;

    ahbseq_top u_ahbseq_top (
        .clk(clk), .rst_n(rst_n), .blk_req(blk_req), .blk_write(blk_write),
        .blk_addr(blk_addr), .blk_words(blk_words), .blk_ack(blk_ack),
        .wr_beat(wr_beat), .wr_data(wr_data), .fch_req(fch_req),
        .fch_addr(fch_addr), .rd_valid(rd_valid), .rd_fetch(rd_fetch),
        .rd_data(rd_data), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
        .hwdata(hwdata), .hrdata(hrdata), .hready(hready)
    );

    // Store data source and bus slave model
    assign wr_data = 32'hD000_0000 + 32'(wr_beat) * 32'd17;
    always @(posedge clk) if (hready) dph_addr <= haddr;
    assign hrdata = dph_addr ^ RD_MASK;

    // HREADY generator
    bit stall_mode = 1'b0;
    int cyc = 0;
    always @(posedge clk) begin
        #2;
        cyc = cyc + 1;
        hready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
    end

    // Monitor
    int          n_chk = 0, n_fail = 0;
    bit          logging = 1'b0;
    logic [1:0]  tr_t [0:63];
    logic [31:0] tr_a [0:63];
    logic        tr_w [0:63];
    int          n_tr, n_rd, n_ack, hold_err, n_hold, wd_err, n_wd;
    logic [31:0] rd_log [0:15];
    logic        rdf_log [0:15];
    logic [31:0] cur_base;
    bit          exp_dwrite, prev_stall;
    logic [7:0]  exp_dbeat;
    logic [1:0]  p_t;
    logic [31:0] p_a, p_d;
    logic        p_w;

    always @(negedge clk) begin
        if (rst_n && logging) begin
            if (prev_stall) begin
                n_hold++;
                if (htrans !== p_t || haddr !== p_a || hwrite !== p_w || hwdata !== p_d)
                    hold_err++;
            end
            prev_stall = !hready;
            p_t = htrans; p_a = haddr; p_w = hwrite; p_d = hwdata;
            if (hready) begin
                if (exp_dwrite) begin
                    n_wd++;
                    if (hwdata !== 32'hD000_0000 + 32'(exp_dbeat) * 32'd17) wd_err++;
                end
                exp_dwrite = (htrans == 2'b10 || htrans == 2'b11) && hwrite;
                exp_dbeat  = 8'((haddr - cur_base) >> 2);
                if (n_tr < 64) begin
                    tr_t[n_tr] = htrans; tr_a[n_tr] = haddr; tr_w[n_tr] = hwrite;
                end
                n_tr++;
            end
            if (rd_valid) begin
                if (n_rd < 16) begin rd_log[n_rd] = rd_data; rdf_log[n_rd] = rd_fetch; end
                n_rd++;
            end
            if (blk_ack) n_ack++;
        end
    end

    task automatic chk(input string req, input string what, input bit ok,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // R1: reset state
    task automatic test_reset;
        @(negedge clk);
        chk("R1", "htrans at rest", htrans == 2'b00, 32'(htrans), 0);
        chk("R1", "hwrite/rd_valid/blk_ack at rest",
            {hwrite, rd_valid, blk_ack} == 3'b000, 32'({hwrite, rd_valid, blk_ack}), 0);
    endtask

    // One scenario: optional block, optional fetch, optional stalls
    task automatic run_case(input string tag, input bit wr, input logic [31:0] base,
                            input int n, input bit with_f, input logic [31:0] faddr,
                            input bit stall);
        logic [1:0]  ex_t [0:15];
        logic [31:0] ex_a [0:15];
        logic        ex_w [0:15];
        int len, s;
        bit ok_t, ok_a;
        logic [31:0] bad_act, bad_exp, bad_aact, bad_aexp;
        int exp_rd, ri;

        @(posedge clk); #1;
        stall_mode = stall;
        #1;
        n_tr = 0; n_rd = 0; n_ack = 0; hold_err = 0; n_hold = 0;
        wd_err = 0; n_wd = 0; exp_dwrite = 0; prev_stall = 0;
        cur_base = base; logging = 1'b1;
        blk_write = wr; blk_addr = base; blk_words = 8'(n); blk_req = (n > 0);
        fch_addr = faddr; fch_req = with_f;
        fork
            begin
                if (n > 0) begin
                    do @(negedge clk); while (!blk_ack);
                    @(posedge clk); #2; blk_req = 1'b0;
                end
            end
            begin
                if (with_f) begin
                    do @(negedge clk); while (!(rd_valid && rd_fetch));
                    @(posedge clk); #2; fch_req = 1'b0;
                end
            end
        join
        repeat (6) @(posedge clk);
        #1; stall_mode = 1'b0;
        #1; logging = 1'b0;

        // Expected address-phase sequence
        len = 0;
        for (int i = 0; i < n; i++) begin
            ex_t[len] = (i == 0) ? 2'b10 : 2'b11;
            ex_a[len] = base + 32'(4 * i); ex_w[len] = wr; len++;
        end
        if (n > 0 && !(wr && with_f)) begin
            ex_t[len] = 2'b00; ex_a[len] = '0; ex_w[len] = 1'b0; len++;
        end
        if (with_f) begin
            ex_t[len] = 2'b10; ex_a[len] = faddr; ex_w[len] = 1'b0; len++;
            ex_t[len] = 2'b00; ex_a[len] = '0; ex_w[len] = 1'b0; len++;
        end
        ex_t[len] = 2'b00; ex_a[len] = '0; ex_w[len] = 1'b0; len++;

        s = -1;
        for (int i = 0; i < n_tr && i < 64; i++)
            if (s < 0 && tr_t[i] != 2'b00) s = i;
        ok_t = (s >= 0); ok_a = (s >= 0);
        bad_act = '1; bad_exp = '1; bad_aact = '1; bad_aexp = '1;
        for (int i = 0; i < len; i++) begin
            int k;
            k = s + i;
            if (s >= 0 && k < n_tr && k < 64) begin
                if (ok_t && {tr_w[k], tr_t[k]} !== {ex_w[i], ex_t[i]}) begin
                    ok_t = 0; bad_act = 32'({tr_w[k], tr_t[k]}); bad_exp = 32'({ex_w[i], ex_t[i]});
                end
                if (ok_a && ex_t[i] != 2'b00 && tr_a[k] !== ex_a[i]) begin
                    ok_a = 0; bad_aact = tr_a[k]; bad_aexp = ex_a[i];
                end
            end else begin
                ok_t = 0; ok_a = 0;
            end
        end
        chk(tag, "htrans/hwrite order (R7)", ok_t, bad_act, bad_exp);
        chk("R2", "address order", ok_a, bad_aact, bad_aexp);

        // Returned words
        exp_rd = (wr ? 0 : n) + (with_f ? 1 : 0);
        chk("R8", "returned word count", n_rd == exp_rd, 32'(n_rd), 32'(exp_rd));
        ri = 0;
        if (!wr) begin
            for (int i = 0; i < n && i < 15; i++) begin
                chk("R8", "load word", rd_log[i] === ((base + 32'(4 * i)) ^ RD_MASK) && !rdf_log[i],
                    rd_log[i], (base + 32'(4 * i)) ^ RD_MASK);
            end
            ri = n;
        end
        if (with_f && ri < 16)
            chk("R6", "fetch word", rd_log[ri] === (faddr ^ RD_MASK) && rdf_log[ri],
                rd_log[ri], faddr ^ RD_MASK);
        if (wr)
            chk("R8", "store data beats", wd_err == 0 && n_wd == n, 32'(n_wd - wd_err), 32'(n));
        chk("R11", "ack count", n_ack == (n > 0 ? 1 : 0), 32'(n_ack), 32'(n > 0 ? 1 : 0));
        if (stall)
            chk("R9", "hold under stall", hold_err == 0 && n_hold > 0, 32'(hold_err), 0);
        chk("R1", "rest after case", htrans == 2'b00 && !hwrite, 32'(htrans), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        test_reset();
        run_case("R5", 1'b0, 32'h0000_1000, 3, 1'b1, 32'h0000_8000, 1'b0);
        run_case("R4/R12", 1'b1, 32'h0000_2000, 3, 1'b1, 32'h0000_8040, 1'b0);
        run_case("R3", 1'b1, 32'h0000_3000, 4, 1'b0, 32'h0, 1'b0);
        run_case("R10", 1'b0, 32'h0000_4000, 1, 1'b0, 32'h0, 1'b0);
        run_case("R6", 1'b0, 32'h0, 0, 1'b1, 32'h0000_9000, 1'b0);
        run_case("R5/R9", 1'b0, 32'h0000_5000, 4, 1'b1, 32'h0000_9100, 1'b1);
        run_case("R4/R9", 1'b1, 32'h0000_6000, 2, 1'b1, 32'h0000_9200, 1'b1);
        run_case("R10/R4", 1'b1, 32'h0000_7000, 1, 1'b1, 32'h0000_9300, 1'b0);
        report();
        $finish;
    end

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule